// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Bit-Rate Divider

This block converts parallel characters into an asynchronous serial line. A programmable divider produces a sample-rate enable from the reference clock. Every bit on the line lasts a fixed number of those enable ticks: 16 ticks for a full bit and 8 for a half bit. The line idles high. Each frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of one, one and a half, or two bit times.

The transmitter is double buffered. A one-character holding stage sits in front of the frame engine, so the host can write the next character while the current one is still on the line. The holding stage empties into the engine as soon as the engine is idle, or at the moment the last stop tick ends. Consecutive characters therefore go out with no gap between them. A break input pulls the line low for as long as it is held, and the frame timing underneath keeps running. Frame format settings are captured at the moment a character enters the engine.

Top module: `async_tx`

## Requirements
- R1: The divider produces one enable tick every `divisor` reference cycles; a divisor of 0 behaves exactly like a divisor of 1.
- R2: A frame begins with a low start bit, each bit lasts exactly 16 enable ticks, and the line is high whenever no frame is in progress.
- R3: `char_len` selects the number of data bits (0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8), sent least significant bit first; unused upper bits of `wr_data` are not sent.
- R4: `par_mode` 1 appends an even parity bit and 2 appends an odd parity bit, computed over the sent data bits only; 0 and 3 send no parity bit.
- R5: `stop_len` 0 gives a high stop period of 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks; the frame ends when the stop period ends.
- R6: While `brk` is high, `txd` is low in every state, and frame timing continues unchanged underneath.
- R7: A write (`wr_en` high for one cycle) is accepted only while `thr_empty` is high; a write while it is low is ignored, and that character is never sent.
- R8: The held character moves into the frame engine in the cycle after the write when the engine is idle, or at the end of the current frame's stop period; its start bit then follows with no idle gap; `thr_empty` rises when the move happens.
- R9: `tx_idle` is high only when both the holding stage and the frame engine are empty; out of reset `txd`, `thr_empty` and `tx_idle` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Reference cycles per enable tick (0 treated as 1) |
| char_len | input | 2 | Data bit count select (5 + value) |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| stop_len | input | 2 | 0 one bit, 1 one and a half bits, 2/3 two bits |
| brk | input | 1 | Force the line low while high |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line |
| thr_empty | output | 1 | Holding stage can take a character |
| tx_idle | output | 1 | Holding stage and frame engine both empty |

## Verification
A write is registered at the first edge. With an idle engine it is loaded at the second edge, so `thr_empty` falls one cycle after the write and returns, with `txd` going low, one cycle after that. The bench fixes time zero at the first sample where the start bit shows. It then samples each bit 8 ticks into its nominal slot, which keeps the samples clear of the up-to-one-tick phase uncertainty of the free-running divider. Frame end is checked through `tx_idle` against a window of total ticks times divisor, and at divisor 1 that window is a single exact cycle. The back-to-back and break runs use divisor 1 and compare every cycle of the line against a computed waveform.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    localparam int OVS     = 16;               // enable ticks per full bit
    localparam int DATA_W  = 8;                // widest character
    localparam int TCNT_W  = $clog2(OVS);
    localparam int STOP_W  = $clog2(2 * OVS);
    localparam int BIDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF  = 2'd3
    } par_mode_e;

    typedef enum logic [1:0] {
        STB_ONE      = 2'd0,
        STB_ONE_HALF = 2'd1,
        STB_TWO      = 2'd2,
        STB_TWO_ALT  = 2'd3
    } stop_len_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] bits;
        logic [BIDX_W-1:0] last_idx;
        logic              par_en;
        logic              par_val;
        logic [STOP_W-1:0] stop_last;
    } frame_t;

    function automatic frame_t build_frame(input logic [DATA_W-1:0] data,
                                           input logic [1:0]        len_sel,
                                           input par_mode_e         pm,
                                           input stop_len_e         sl);
        frame_t            f;
        logic [DATA_W-1:0] mask;
        mask        = {DATA_W{1'b1}} >> (2'd3 - len_sel);
        f.bits      = data & mask;
        f.last_idx  = BIDX_W'(len_sel) + BIDX_W'(4);
        f.par_en    = (pm == PAR_EVEN) || (pm == PAR_ODD);
        f.par_val   = (pm == PAR_ODD) ? ~(^f.bits) : (^f.bits);
        case (sl)
            STB_ONE:      f.stop_last = STOP_W'(OVS - 1);
            STB_ONE_HALF: f.stop_last = STOP_W'(OVS + OVS / 2 - 1);
            default:      f.stop_last = STOP_W'(2 * OVS - 1);
        endcase
        return f;
    endfunction

endpackage

// File: rtl/tx_baud_div.sv
module tx_baud_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = (divisor == '0) ? '0 : divisor - DIV_W'(1);
    assign tick  = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && divisor > DIV_W'(1)) |=> (!tick || divisor < DIV_W'(2)));

endmodule

// File: rtl/tx_hold.sv
module tx_hold
    import async_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data
);
    logic accept;

    assign accept = wr_en && !hold_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (take) begin
            hold_valid <= 1'b0;
        end else if (accept) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
        end
    end

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_valid && !take) |=> (hold_valid && $stable(hold_data)));

    // R8
    take_valid_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> hold_valid);

endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
    import async_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [1:0]        char_len,
    input  logic [1:0]        par_mode,
    input  logic [1:0]        stop_len,
    output logic              take,
    output logic              ser_bit,
    output logic              busy
);
    tx_state_e         state;
    frame_t            cur;
    frame_t            nxt;
    logic [TCNT_W-1:0] tcnt;
    logic [BIDX_W-1:0] bidx;
    logic [STOP_W-1:0] scnt;
    logic              bit_end;
    logic              stop_end;

    assign nxt      = build_frame(hold_data, char_len, par_mode_e'(par_mode),
                                  stop_len_e'(stop_len));
    assign bit_end  = tick && (tcnt == TCNT_W'(OVS - 1));
    assign stop_end = (state == ST_STOP) && tick && (scnt == cur.stop_last);
    assign take     = hold_valid && ((state == ST_IDLE) || stop_end);
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            tcnt  <= '0;
            bidx  <= '0;
            scnt  <= '0;
        end else if (take) begin
            state <= ST_START;
            cur   <= nxt;
            tcnt  <= '0;
            bidx  <= '0;
            scnt  <= '0;
        end else if (tick) begin
            tcnt <= bit_end ? '0 : tcnt + TCNT_W'(1);
            case (state)
                ST_START: if (bit_end) state <= ST_DATA;
                ST_DATA: begin
                    if (bit_end) begin
                        if (bidx == cur.last_idx) begin
                            state <= cur.par_en ? ST_PARITY : ST_STOP;
                            scnt  <= '0;
                        end else begin
                            bidx <= bidx + BIDX_W'(1);
                        end
                    end
                end
                ST_PARITY: begin
                    if (bit_end) begin
                        state <= ST_STOP;
                        scnt  <= '0;
                    end
                end
                ST_STOP: begin
                    if (scnt == cur.stop_last) state <= ST_IDLE;
                    else                       scnt  <= scnt + STOP_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_START:  ser_bit = 1'b0;
            ST_DATA:   ser_bit = cur.bits[bidx];
            ST_PARITY: ser_bit = cur.par_val;
            default:   ser_bit = 1'b1;
        endcase
    end

    // R2
    bit_steady_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_START || state == ST_DATA || state == ST_PARITY) && !tick)
        |=> ($stable(state) && $stable(ser_bit)));

    // R3
    bit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (bidx <= cur.last_idx));

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && !tick) |=> (state == ST_STOP));

endmodule

// File: rtl/async_tx.sv
module async_tx
    import async_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       char_len,
    input  logic [1:0]       par_mode,
    input  logic [1:0]       stop_len,
    input  logic             brk,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             txd,
    output logic             thr_empty,
    output logic             tx_idle
);
    logic              tick;
    logic              take;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              ser_bit;
    logic              busy;

    tx_baud_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .divisor (divisor),
        .tick    (tick)
    );

    tx_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (take),
        .hold_valid (hold_valid),
        .hold_data  (hold_data)
    );

    tx_frame_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .char_len   (char_len),
        .par_mode   (par_mode),
        .stop_len   (stop_len),
        .take       (take),
        .ser_bit    (ser_bit),
        .busy       (busy)
    );

    assign txd       = brk ? 1'b0 : ser_bit;
    assign thr_empty = !hold_valid;
    assign tx_idle   = !busy && !hold_valid;

    // R9
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> (txd || brk));

endmodule

// File: tb/async_tx_bench.sv
module async_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] divisor = 16'd1;
    logic [1:0]  char_len = 2'd3;
    logic [1:0]  par_mode = 2'd0;
    logic [1:0]  stop_len = 2'd0;
    logic        brk = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        txd, thr_empty, tx_idle;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    async_tx u_async_tx (
        .clk(clk), .rst(rst), .divisor(divisor), .char_len(char_len),
        .par_mode(par_mode), .stop_len(stop_len), .brk(brk), .wr_en(wr_en),
        .wr_data(wr_data), .txd(txd), .thr_empty(thr_empty), .tx_idle(tx_idle)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected line level for two back-to-back 8N1 frames, k cycles after start at divisor 1
    function automatic int two_frame_level(int k, logic [7:0] a, logic [7:0] b);
        int f, bi;
        logic [7:0] c;
        if (k >= 320) return 1;
        f  = k / 160;
        bi = (k % 160) / 16;
        c  = (f == 0) ? a : b;
        if (bi == 0) return 0;
        if (bi <= 8) return int'(c[bi-1]);
        return 1;
    endfunction

    task automatic frame_test(logic [7:0] d, int cl, int pm, int ss, int dv);
        int eff, nb, pe, stt, per, tot, pos, guard, ones, tgt;
        logic [7:0] md;
        eff = (dv == 0) ? 1 : dv;
        nb  = 5 + cl;
        pe  = (pm == 1 || pm == 2) ? 1 : 0;
        stt = (ss == 0) ? 16 : (ss == 1) ? 24 : 32;
        per = 16 * eff;
        md  = d & (8'hFF >> (8 - nb));
        @(negedge clk);
        divisor  = 16'(dv);
        char_len = 2'(cl);
        par_mode = 2'(pm);
        stop_len = 2'(ss);
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 write taken while empty", thr_empty, 0);
        guard = 0;
        while (txd === 1'b1 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        pos = 0;
        tgt = 8 * eff;
        step(tgt - pos); pos = tgt;
        check("R2 start bit low", txd, 0);
        for (int i = 0; i < nb; i++) begin
            tgt = per * (i + 1) + 8 * eff;
            step(tgt - pos); pos = tgt;
            check("R3 data bit LSB first", txd, int'(md[i]));
        end
        if (pe == 1) begin
            ones = $countones(md);
            tgt = per * (nb + 1) + 8 * eff;
            step(tgt - pos); pos = tgt;
            check("R4 parity bit", txd, (pm == 1) ? (ones % 2) : (1 - ones % 2));
        end
        tgt = per * (1 + nb + pe) + 4 * eff;
        step(tgt - pos); pos = tgt;
        check("R5 stop level high", txd, 1);
        tot = 16 * (1 + nb + pe) + stt;
        guard = 0;
        while (!tx_idle && guard < 5000) begin
            step(1); pos++; guard++;
        end
        check("R1 R5 frame length window", int'(pos >= (tot - 1) * eff + 1 && pos <= tot * eff), 1);
        if (dv <= 1 && !(pos == tot))
            check("R1 R5 exact frame length at divisor 0/1", pos, tot);
    endtask

    initial begin
        step(3);
        check("R9 reset txd", txd, 1);
        check("R9 reset thr_empty", thr_empty, 1);
        check("R9 reset tx_idle", tx_idle, 1);
        rst = 1'b0;
        step(2);
        check("R9 idle line after reset", txd, 1);

        // Format sweep at divisor 1
        for (int cl = 0; cl < 4; cl++)
            for (int pm = 0; pm < 4; pm++)
                for (int ss = 0; ss < 4; ss++) begin
                    frame_test(8'hA5 ^ 8'(cl * 16 + pm * 4 + ss), cl, pm, ss, 1);
                    frame_test(8'h3C ^ 8'(ss * 32 + cl * 4 + pm), cl, pm, ss, 1);
                end

        // Divider values, R1
        frame_test(8'h96, 3, 0, 0, 0);
        frame_test(8'h4B, 2, 2, 1, 0);
        frame_test(8'hD2, 2, 2, 1, 3);
        frame_test(8'h1F, 0, 1, 2, 5);
        frame_test(8'hE7, 3, 1, 1, 2);

        // Break while idle, R6
        @(negedge clk);
        divisor = 16'd1; char_len = 2'd3; par_mode = 2'd0; stop_len = 2'd0;
        brk = 1'b1;
        #1 check("R6 break forces low when idle", txd, 0);
        step(5);
        check("R6 break held low", txd, 0);
        check("R9 idle during break", tx_idle, 1);
        brk = 1'b0;
        #1 check("R6 line returns high after break", txd, 1);

        // Double buffering and ignored write, R7 R8 R9
        @(negedge clk);
        wr_data = 8'h6D; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 holding full after write", thr_empty, 0);
        check("R9 not idle with held char", tx_idle, 0);
        @(negedge clk);
        check("R8 immediate load start bit", txd, 0);
        check("R8 holding empty after immediate load", thr_empty, 1);
        wr_data = 8'hC3; wr_en = 1'b1;
        @(negedge clk);
        check("R7 second write taken", thr_empty, 0);
        check("R2 line at pos1", txd, two_frame_level(1, 8'h6D, 8'hC3));
        wr_data = 8'h11; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 2; k <= 400; k++) begin
            check("R7 R8 back-to-back line, ignored write absent", txd, two_frame_level(k, 8'h6D, 8'hC3));
            if (k == 100) begin
                check("R8 holding still full mid frame", thr_empty, 0);
                check("R9 busy mid frame", tx_idle, 0);
            end
            if (k == 161) check("R8 holding empties at frame end", thr_empty, 1);
            if (k == 200) check("R9 busy second frame", tx_idle, 0);
            if (k == 320) check("R9 idle after both frames", tx_idle, 1);
            step(1);
        end

        // Break in the middle of a frame, R6
        @(negedge clk);
        wr_data = 8'hFF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        for (int k = 0; k <= 170; k++) begin
            brk = (k >= 20 && k < 60);
            #1;
            if (brk) check("R6 break overrides frame", txd, 0);
            else     check("R6 frame level outside break", txd, (k < 16) ? 0 : 1);
            if (k == 160) check("R6 frame timing unchanged by break", tx_idle, 1);
            @(negedge clk);
        end
        brk = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule